// File: doc/BRIEF.md
# Loop Closure Detector

This block watches a stream of signed line-current samples and decides whether the subscriber loop is closed (off-hook) or open (on-hook). Each accepted sample first passes through a first-order low-pass filter whose gain is programmable. The filter removes ringing and other AC residue, so the later stages act only on the DC level of the loop current.

The filtered value drives a comparator with two thresholds, which gives it hysteresis. A debounce counter follows the comparator. It changes the reported loop state only after the comparator has disagreed with that state for a full programmed number of samples. When a ringing burst ends, a pulse starts a mask timer. While the timer runs, the comparator and the debounce are frozen, so current transients from a heavy ringer load are not taken as a hook change. A one-clock interrupt pulse marks every change of the reported state.

The filter coefficient is fixed-point with 14 fractional bits, so 0x4000 means a gain of one. A target cutoff f maps to a coefficient of roughly 2·(2π·f·4096/800). A value near 0x0A10 is a typical choice.

Top module: `loop_closure_det`

## Requirements
- R1: After reset, `loop_closed_o` and `loop_irq_o` are 0, the filter state is 0, and the debounce and mask counters are clear.
- R2: On each cycle with `smp_vld_i` high, the filter state y becomes y + floor(coef·(x − y) / 2^14). With coefficient 0x4000 the new y equals x. With coefficient 0 y stays at its value.
- R3: A `coef_i` value above 0x4000 is treated as 0x4000.
- R4: The comparator level goes from open to closed only when the new filtered value is strictly greater than `thr_close_i`. It goes from closed to open only when that value is strictly less than `thr_open_i`. Otherwise it keeps its level. Both thresholds are signed.
- R5: On an unmasked sample, a comparator level equal to the reported state clears the debounce count. A differing level flips the reported state on the (`dbnc_len_i`+1)-th consecutive differing sample, so a length of 0 flips on the first one. The new state is visible in the cycle after the sampling edge.
- R6: `loop_irq_o` is high for exactly the cycle in which `loop_closed_o` first shows a new value, for both the closing and the opening direction, and is low otherwise.
- R7: A `ring_done_i` pulse loads the mask counter with `mask_len_i`. The next `mask_len_i` samples are masked: the comparator level and the debounce count hold, but the filter keeps running. A length of 0 masks nothing. A sample in the same cycle as the pulse is the first masked one.
- R8: In cycles without `smp_vld_i`, the input sample has no effect, and `loop_closed_o` does not change.
- R9: Debounce and mask lengths work up to their maximum value 2^TW − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | DW | Signed loop current sample |
| coef_i | input | CW | Filter coefficient, 0x4000 = unity |
| thr_close_i | input | DW | Signed threshold for detecting closure |
| thr_open_i | input | DW | Signed threshold for detecting opening |
| dbnc_len_i | input | TW | Debounce length in samples |
| mask_len_i | input | TW | Mask length in samples after a ringing burst |
| ring_done_i | input | 1 | Pulse at the end of a ringing burst |
| loop_closed_o | output | 1 | Debounced loop state, 1 = closed |
| loop_irq_o | output | 1 | One-cycle pulse on every state change |

## Verification
The bench builds the block with 16-bit samples, a 15-bit coefficient and 8-bit interval counters. The 8-bit counters keep the largest debounce length (255) within a few hundred samples, so the full-length boundary of the counter is tested directly. The 16-bit sample width allows the exact threshold values and the halving effect of coefficient 0x2000 to be checked against hand-computed results. The 15-bit coefficient width leaves room for values above 0x4000, which tests the clamp.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    // Fractional bits of the filter coefficient: 1 << COEF_FRAC is unity gain.
    localparam int COEF_FRAC = 14;

    typedef enum logic {
        LINE_OPEN   = 1'b0,
        LINE_CLOSED = 1'b1
    } line_e;
endpackage

// File: rtl/lcd_lpf.sv
module lcd_lpf #(
    parameter int DW = 16,
    parameter int CW = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic        [CW-1:0] coef_i,
    output logic signed [DW-1:0] y_nxt_o
);
    import lcd_pkg::*;

    localparam int PW = DW + CW + 2;
    localparam logic [CW-1:0] UNITY = CW'(1) << COEF_FRAC;

    typedef struct packed {
        logic signed [DW-1:0] y;
    } lpf_st_t;

    lpf_st_t st_d, st_q;
    logic [CW-1:0]        coef_eff;
    logic signed [DW:0]   diff;
    logic signed [PW-1:0] prod;

    always_comb begin
        st_d     = st_q;
        coef_eff = (coef_i > UNITY) ? UNITY : coef_i;
        diff     = $signed({smp_i[DW-1], smp_i}) - $signed({st_q.y[DW-1], st_q.y});
        prod     = PW'(diff) * PW'($signed({1'b0, coef_eff}));
        if (smp_vld_i) begin
            st_d.y = st_q.y + DW'(prod >>> COEF_FRAC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_nxt_o = st_d.y;
endmodule

// File: rtl/lcd_hyst.sv
module lcd_hyst #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld_i,
    input  logic                 hold_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [DW-1:0] thr_close_i,
    input  logic signed [DW-1:0] thr_open_i,
    output lcd_pkg::line_e       level_nxt_o
);
    import lcd_pkg::*;

    typedef struct packed {
        line_e level;
    } hyst_st_t;

    hyst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_vld_i && !hold_i) begin
            if (st_q.level == LINE_OPEN) begin
                if (y_i > thr_close_i) st_d.level = LINE_CLOSED;
            end else begin
                if (y_i < thr_open_i)  st_d.level = LINE_OPEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{level: LINE_OPEN};
        else        st_q <= st_d;
    end

    assign level_nxt_o = st_d.level;
endmodule

// File: rtl/lcd_mask.sv
module lcd_mask #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld_i,
    input  logic          ring_done_i,
    input  logic [TW-1:0] mask_len_i,
    output logic          active_o
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ring_done_i) begin
            active_o = (mask_len_i != '0);
            st_d.cnt = mask_len_i;
        end else begin
            active_o = (st_q.cnt != '0);
        end
        if (smp_vld_i && active_o) begin
            st_d.cnt = st_d.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_debounce.sv
module lcd_debounce #(
    parameter int TW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld_i,
    input  logic           hold_i,
    input  lcd_pkg::line_e level_i,
    input  logic [TW-1:0]  dbnc_len_i,
    output logic           closed_o,
    output logic           irq_o
);
    import lcd_pkg::*;

    typedef struct packed {
        line_e         state;
        logic [TW-1:0] cnt;
        logic          irq;
    } dbn_st_t;

    dbn_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (smp_vld_i && !hold_i) begin
            if (level_i == st_q.state) begin
                st_d.cnt = '0;
            end else if (st_q.cnt >= dbnc_len_i) begin
                st_d.state = level_i;
                st_d.cnt   = '0;
                st_d.irq   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: LINE_OPEN, cnt: '0, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign closed_o = (st_q.state == LINE_CLOSED);
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/loop_closure_det.sv
module loop_closure_det #(
    parameter int DW = 16,
    parameter int CW = 15,
    parameter int TW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld_i,
    input  logic signed [DW-1:0] smp_i,
    input  logic        [CW-1:0] coef_i,
    input  logic signed [DW-1:0] thr_close_i,
    input  logic signed [DW-1:0] thr_open_i,
    input  logic        [TW-1:0] dbnc_len_i,
    input  logic        [TW-1:0] mask_len_i,
    input  logic                 ring_done_i,
    output logic                 loop_closed_o,
    output logic                 loop_irq_o
);
    logic signed [DW-1:0] y_nxt;
    logic                 mask_active;
    lcd_pkg::line_e       level_nxt;

    lcd_lpf #(.DW(DW), .CW(CW)) lpf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld_i (smp_vld_i),
        .smp_i     (smp_i),
        .coef_i    (coef_i),
        .y_nxt_o   (y_nxt)
    );

    lcd_mask #(.TW(TW)) mask_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld_i   (smp_vld_i),
        .ring_done_i (ring_done_i),
        .mask_len_i  (mask_len_i),
        .active_o    (mask_active)
    );

    lcd_hyst #(.DW(DW)) hyst_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld_i   (smp_vld_i),
        .hold_i      (mask_active),
        .y_i         (y_nxt),
        .thr_close_i (thr_close_i),
        .thr_open_i  (thr_open_i),
        .level_nxt_o (level_nxt)
    );

    lcd_debounce #(.TW(TW)) dbn_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld_i  (smp_vld_i),
        .hold_i     (mask_active),
        .level_i    (level_nxt),
        .dbnc_len_i (dbnc_len_i),
        .closed_o   (loop_closed_o),
        .irq_o      (loop_irq_o)
    );
endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_vld,
    input logic mask_act,
    input logic closed,
    input logic irq
);
    // R1: the cycle after reset is held, both outputs are low
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!closed && !irq));

    // R6: every change of the state is flagged
    a_r6_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (closed != $past(closed)) |-> irq);

    // R6: the pulse never appears without a change
    a_r6_irq_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (closed != $past(closed)));

    // R8: a cycle without a sample leaves the state alone and raises no pulse
    a_r8_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(closed) && !irq));

    // R7: a masked sample cannot move the state
    a_r7_mask_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && mask_act) |=> $stable(closed));
endmodule

bind loop_closure_det lcd_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld_i),
    .mask_act (mask_active),
    .closed   (loop_closed_o),
    .irq      (loop_irq_o)
);

// File: tb/loop_closure_det_tb_top.sv
module loop_closure_det_tb_top;
    localparam int DW = 16;
    localparam int CW = 15;
    localparam int TW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_vld = 1'b0;
    logic signed [DW-1:0] smp = '0;
    logic        [CW-1:0] coef = '0;
    logic signed [DW-1:0] thr_close = '0;
    logic signed [DW-1:0] thr_open = '0;
    logic        [TW-1:0] dbnc_len = '0;
    logic        [TW-1:0] mask_len = '0;
    logic                 ring_done = 1'b0;
    logic                 closed;
    logic                 irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    loop_closure_det #(.DW(DW), .CW(CW), .TW(TW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_vld_i     (smp_vld),
        .smp_i         (smp),
        .coef_i        (coef),
        .thr_close_i   (thr_close),
        .thr_open_i    (thr_open),
        .dbnc_len_i    (dbnc_len),
        .mask_len_i    (mask_len),
        .ring_done_i   (ring_done),
        .loop_closed_o (closed),
        .loop_irq_o    (irq)
    );

    typedef struct packed {
        logic signed [15:0] x;
        logic               st;
        logic               pulse;
    } vec_t;

    // Unity coefficient, close above 1000, open below 500, debounce length 2.
    localparam vec_t VEC [0:20] = '{
        '{16'sd2000, 1'b0, 1'b0}, '{16'sd2000, 1'b0, 1'b0}, '{16'sd2000, 1'b1, 1'b1},
        '{16'sd2000, 1'b1, 1'b0}, '{16'sd700,  1'b1, 1'b0}, '{16'sd100,  1'b1, 1'b0},
        '{16'sd800,  1'b1, 1'b0}, '{16'sd800,  1'b0, 1'b1}, '{16'sd3000, 1'b0, 1'b0},
        '{16'sd0,    1'b0, 1'b0}, '{16'sd3000, 1'b0, 1'b0}, '{16'sd3000, 1'b0, 1'b0},
        '{16'sd3000, 1'b1, 1'b1}, '{-16'sd500, 1'b1, 1'b0}, '{16'sd1200, 1'b1, 1'b0},
        '{16'sd500,  1'b1, 1'b0}, '{16'sd499,  1'b1, 1'b0}, '{16'sd499,  1'b1, 1'b0},
        '{16'sd499,  1'b0, 1'b1}, '{16'sd1000, 1'b0, 1'b0}, '{16'sd1001, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {closed,irq} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        smp_vld   = 1'b0;
        ring_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg(input logic [CW-1:0] c, input int cl, input int op,
                       input int db, input int mk);
        coef      = c;
        thr_close = DW'(cl);
        thr_open  = DW'(op);
        dbnc_len  = TW'(db);
        mask_len  = TW'(mk);
    endtask

    // Drive one sample; on return the outputs after the sampling edge are stable.
    task automatic sample(input int x);
        smp     = DW'(x);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic ring_pulse();
        ring_done = 1'b1;
        @(negedge clk);
        ring_done = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cfg(15'h4000, 1000, 500, 2, 0);
        do_reset();
        check("R1 reset", {closed, irq}, 2'b00);

        // R4/R5/R6: table walk
        for (int i = 0; i < 21; i++) begin
            sample(int'(VEC[i].x));
            check($sformatf("R5 vector %0d", i), {closed, irq}, {VEC[i].st, VEC[i].pulse});
        end

        // R5: zero debounce flips on the first sample; R6: pulse lasts one cycle
        cfg(15'h4000, 1000, 500, 0, 0);
        do_reset();
        sample(2000);
        check("R5 zero length", {closed, irq}, 2'b11);
        @(negedge clk);
        check("R6 single cycle pulse", {closed, irq}, 2'b10);
        // R8: input swings without a strobe
        smp = -16'sd30000;
        repeat (5) @(negedge clk);
        check("R8 no strobe", {closed, irq}, 2'b10);

        // R2: coefficient 0 passes nothing
        cfg(15'h0000, 1000, 500, 0, 0);
        do_reset();
        repeat (5) sample(30000);
        check("R2 zero coef", {closed, irq}, 2'b00);

        // R1/R2: half coefficient from a zero state: 800, then 1200
        cfg(15'h2000, 1000, 500, 0, 0);
        do_reset();
        sample(1600);
        check("R2 half step 1", {closed, irq}, 2'b00);
        sample(1600);
        check("R2 half step 2", {closed, irq}, 2'b11);

        // R3: oversized coefficient clamps to unity: y = 1600, not above 2000
        cfg(15'h7FFF, 2000, 500, 0, 0);
        do_reset();
        sample(1600);
        check("R3 clamp", {closed, irq}, 2'b00);

        // R7: mask of 3 hides three samples
        cfg(15'h4000, 1000, 500, 0, 3);
        do_reset();
        ring_pulse();
        check("R7 after pulse", {closed, irq}, 2'b00);
        for (int k = 0; k < 3; k++) begin
            sample(2000);
            check($sformatf("R7 masked %0d", k), {closed, irq}, 2'b00);
        end
        sample(2000);
        check("R7 mask expired", {closed, irq}, 2'b11);

        // R7: ring pulse with zero mask masks nothing
        cfg(15'h4000, 1000, 500, 0, 0);
        do_reset();
        ring_pulse();
        sample(2000);
        check("R7 zero mask", {closed, irq}, 2'b11);

        // R7: pulse together with a sample makes that sample the first masked one
        cfg(15'h4000, 1000, 500, 0, 1);
        do_reset();
        ring_done = 1'b1;
        sample(2000);
        ring_done = 1'b0;
        check("R7 same cycle", {closed, irq}, 2'b00);
        sample(2000);
        check("R7 same cycle expired", {closed, irq}, 2'b11);

        // R9: maximum debounce length 255 needs 256 samples
        cfg(15'h4000, 1000, 500, 255, 0);
        do_reset();
        repeat (255) sample(2000);
        check("R9 max minus one", {closed, irq}, 2'b00);
        sample(2000);
        check("R9 max length", {closed, irq}, 2'b11);

        // R1: reset while closed clears the state
        do_reset();
        check("R1 reset while closed", {closed, irq}, 2'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule